// File: doc/BRIEF.md
# Grey-Scale Framebuffer Scan-Out

This block turns a packed 4-bit grey-scale framebuffer into a scaled pixel stream for a display pipeline. Each framebuffer byte holds two horizontally adjacent source pixels. The block walks the visible source area row by row. It repeats every source pixel SCALE times across a line and every source line SCALE times down the frame. With the default geometry, a 128 by 64 source becomes a 512 by 256 output. Each grey level is widened to 16-bit RGB565 by default, or to 24-bit RGB when a parameter selects that variant.

The block only scans when a redraw has been requested. A request sets a pending flag. The flag stays set for the whole scan and drops when the final pixel of the frame is handed to the output register. A request that arrives while a scan is running is remembered, and it causes exactly one more frame after the current one.

The framebuffer is read through a synchronous read port with one cycle of latency. The output is a registered stream with valid, start-of-frame and end-of-line markers. A ready input applies backpressure.

Top module: `gsfb_scanout`

## Requirements
- R1: After reset, pix_valid, pix_sof, pix_eol and redraw_pending are 0 and fb_addr is 0.
- R2: While no redraw is pending, pix_valid stays 0 and no frame is produced.
- R3: A frame is (SRC_W*SCALE)*(SRC_H*SCALE) accepted pixels in raster order. pix_sof is 1 only on the first pixel of the frame. pix_eol is 1 exactly on the last pixel of each output line.
- R4: Source row r, byte b is read from address r*(SRC_W/2)+b, and only rows 0 to SRC_H-1 are read. A source row is fetched again for each of its SCALE output lines, so one frame makes SCALE*SRC_H*(SRC_W/2) address changes. The last of these returns the address to 0.
- R5: Within a byte, bits [7:4] are the left pixel and bits [3:0] are the right pixel.
- R6: Each source pixel appears on SCALE consecutive output pixels, and each group of SCALE consecutive output lines is identical.
- R7: In 16-bit mode, grey g gives n = 2g + g[3] (5 bits). The pixel is red = n in bits [15:11], green = {n, n[4]} in bits [10:5] and blue = n in bits [4:0]. For example, g=8 gives 16'h8C71 and g=1 gives 16'h1082.
- R8: In 24-bit mode (COLOR24=1), each 8-bit channel is {g, g}, so g=15 gives 24'hFFFFFF and g=8 gives 24'h888888.
- R9: redraw_pending drops once the last pixel of a frame has been issued, and it stays set for the whole time a scan is in progress.
- R10: A redraw request made while a scan is running produces exactly one further full frame after the current one. Pending then clears.
- R11: While pix_valid is 1 and pix_ready is 0, pix_data, pix_sof, pix_eol, pix_valid and fb_addr hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redraw_req | input | 1 | One-cycle request for a new frame |
| redraw_pending | output | 1 | Frame requested and not yet fully issued |
| fb_addr | output | $clog2(SRC_H*SRC_W/2) | Framebuffer byte address |
| fb_rdata | input | 8 | Read data, valid one cycle after the address |
| pix_ready | input | 1 | Downstream accepts the current pixel |
| pix_valid | output | 1 | Output pixel valid |
| pix_sof | output | 1 | First pixel of a frame |
| pix_eol | output | 1 | Last pixel of an output line |
| pix_data | output | 16 or 24 | RGB565, or RGB888 when COLOR24=1 |

## Verification
A counter that goes wrong inside the scan shows up in the same frame. A sub-pixel counter error breaks the SCALE-fold horizontal runs or swaps nibbles within the next byte. A repeat or row counter error puts pix_eol in the wrong place, misplaces the frame length and pix_sof, or sends fb_addr along the wrong path on the next line boundary. The bench compares every pixel and every address change against a model of the requirements. A pending flag that is lost or stuck becomes visible within a few cycles of a frame's end: either no second frame follows a request made during a scan, or pixels keep coming when nothing is pending. Stalls are checked on every cycle that ready is low.

// File: rtl/gsfb_pkg.sv
package gsfb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_EMIT
  } scan_state_t;
endpackage

// File: rtl/gsfb_redraw_ctl.sv
module gsfb_redraw_ctl (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic frame_start,
  input  logic frame_done,
  output logic pending
);
  logic in_scan_q;
  logic again_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_scan_q <= 1'b0;
      again_q   <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (frame_done) begin
        in_scan_q <= 1'b0;
        again_q   <= 1'b0;
        pend_q    <= again_q | req;
      end else begin
        if (frame_start) in_scan_q <= 1'b1;
        if (req && (in_scan_q || frame_start)) again_q <= 1'b1;
        if (req) pend_q <= 1'b1;
      end
    end
  end

  assign pending = pend_q;

  AST_START_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> pend_q); // R2
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !again_q && !req) |=> !pend_q); // R9
  AST_REQ_SETS: assert property (@(posedge clk) disable iff (rst)
    req |=> pend_q); // R10
endmodule

// File: rtl/gsfb_scan_cnt.sv
module gsfb_scan_cnt #(
  parameter int SRC_H     = 64,
  parameter int ROW_BYTES = 64,
  parameter int SCALE     = 4,
  parameter int AW        = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          hi_nib,
  output logic          at_origin,
  output logic          byte_end,
  output logic          line_end,
  output logic          frame_end
);
  localparam int SUB_N = 2 * SCALE;
  localparam int SUBW  = (SUB_N > 1) ? $clog2(SUB_N) : 1;
  localparam int BW    = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1;
  localparam int RW    = (SCALE > 1) ? $clog2(SCALE) : 1;
  localparam int HW    = (SRC_H > 1) ? $clog2(SRC_H) : 1;
  localparam int TOTAL = SRC_H * ROW_BYTES;

  logic [SUBW-1:0] sub_q;
  logic [BW-1:0]   col_q;
  logic [RW-1:0]   rep_q;
  logic [HW-1:0]   row_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   base_q;
  logic            rep_last;
  logic            row_last;
  logic            col_last;

  assign byte_end  = (sub_q == SUBW'(SUB_N - 1));
  assign col_last  = (col_q == BW'(ROW_BYTES - 1));
  assign rep_last  = (rep_q == RW'(SCALE - 1));
  assign row_last  = (row_q == HW'(SRC_H - 1));
  assign line_end  = byte_end && col_last;
  assign frame_end = line_end && rep_last && row_last;
  assign hi_nib    = ({1'b0, sub_q} < (SUBW+1)'(SCALE));
  assign at_origin = (sub_q == '0) && (col_q == '0) && (rep_q == '0) && (row_q == '0);
  assign addr      = addr_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sub_q  <= '0;
      col_q  <= '0;
      rep_q  <= '0;
      row_q  <= '0;
      addr_q <= '0;
      base_q <= '0;
    end else if (step) begin
      if (!byte_end) begin
        sub_q <= sub_q + 1'b1;
      end else begin
        sub_q <= '0;
        if (!col_last) begin
          col_q  <= col_q + 1'b1;
          addr_q <= addr_q + 1'b1;
        end else begin
          col_q <= '0;
          if (!rep_last) begin
            rep_q  <= rep_q + 1'b1;
            addr_q <= base_q;
          end else begin
            rep_q <= '0;
            if (!row_last) begin
              row_q  <= row_q + 1'b1;
              base_q <= base_q + AW'(ROW_BYTES);
              addr_q <= base_q + AW'(ROW_BYTES);
            end else begin
              row_q  <= '0;
              base_q <= '0;
              addr_q <= '0;
            end
          end
        end
      end
    end
  end

  AST_ADDR_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    {1'b0, addr_q} < (AW+1)'(TOTAL)); // R4
  AST_ROW_BASE: assert property (@(posedge clk) disable iff (rst)
    (sub_q == '0 && col_q == '0) |-> (addr_q == base_q)); // R4
endmodule

// File: rtl/gsfb_grey_expand.sv
module gsfb_grey_expand #(
  parameter bit COLOR24 = 1'b0,
  parameter int PIX_W   = 16
) (
  input  logic [3:0]       grey,
  output logic [PIX_W-1:0] pix
);
  generate
    if (COLOR24) begin : g_rgb888
      always_comb pix = PIX_W'({grey, grey, grey, grey, grey, grey});
    end else begin : g_rgb565
      logic [4:0] lvl;
      always_comb begin
        lvl = {grey, 1'b0} + {4'b0000, grey[3]};
        pix = PIX_W'({lvl, lvl, lvl[4], lvl});
      end
    end
  endgenerate
endmodule

// File: rtl/gsfb_scanout.sv
module gsfb_scanout
  import gsfb_pkg::*;
#(
  parameter int  SRC_W     = 128,
  parameter int  SRC_H     = 64,
  parameter int  SCALE     = 4,
  parameter bit  COLOR24   = 1'b0,
  localparam int ROW_BYTES = SRC_W / 2,
  localparam int AW        = (SRC_H * ROW_BYTES > 1) ? $clog2(SRC_H * ROW_BYTES) : 1,
  localparam int PIX_W     = COLOR24 ? 24 : 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             redraw_req,
  output logic             redraw_pending,
  output logic [AW-1:0]    fb_addr,
  input  logic [7:0]       fb_rdata,
  input  logic             pix_ready,
  output logic             pix_valid,
  output logic             pix_sof,
  output logic             pix_eol,
  output logic [PIX_W-1:0] pix_data
);
  scan_state_t      state_q;
  logic [7:0]       hold_q;
  logic             slot_free;
  logic             emit;
  logic             frame_start;
  logic             frame_done;
  logic             hi_nib;
  logic             at_origin;
  logic             byte_end;
  logic             line_end;
  logic             frame_end;
  logic [3:0]       grey;
  logic [PIX_W-1:0] pix_next;

  assign slot_free   = !pix_valid || pix_ready;
  assign emit        = (state_q == ST_EMIT) && slot_free;
  assign frame_start = (state_q == ST_IDLE) && redraw_pending;
  assign frame_done  = emit && frame_end;
  assign grey        = hi_nib ? hold_q[7:4] : hold_q[3:0];

  gsfb_redraw_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .req         (redraw_req),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .pending     (redraw_pending)
  );

  gsfb_scan_cnt #(
    .SRC_H     (SRC_H),
    .ROW_BYTES (ROW_BYTES),
    .SCALE     (SCALE),
    .AW        (AW)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clr       (frame_start),
    .step      (emit),
    .addr      (fb_addr),
    .hi_nib    (hi_nib),
    .at_origin (at_origin),
    .byte_end  (byte_end),
    .line_end  (line_end),
    .frame_end (frame_end)
  );

  gsfb_grey_expand #(
    .COLOR24 (COLOR24),
    .PIX_W   (PIX_W)
  ) u_exp (
    .grey (grey),
    .pix  (pix_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE:  if (redraw_pending) state_q <= ST_FETCH;
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD: begin
          hold_q  <= fb_rdata;
          state_q <= ST_EMIT;
        end
        ST_EMIT: begin
          if (emit && byte_end) state_q <= frame_end ? ST_IDLE : ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_sof   <= 1'b0;
      pix_eol   <= 1'b0;
      pix_data  <= '0;
    end else if (emit) begin
      pix_valid <= 1'b1;
      pix_sof   <= at_origin;
      pix_eol   <= line_end;
      pix_data  <= pix_next;
    end else if (pix_ready) begin
      pix_valid <= 1'b0;
      pix_sof   <= 1'b0;
      pix_eol   <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data) && $stable(pix_sof)
                                   && $stable(pix_eol) && $stable(fb_addr))); // R11
  AST_SOF_VALID: assert property (@(posedge clk) disable iff (rst)
    (pix_sof || pix_eol) |-> pix_valid); // R3
  AST_SCAN_PENDING: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |-> redraw_pending); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!redraw_pending && !pix_valid) |=> !pix_valid); // R2
endmodule

// File: tb/gsfb_scanout_tb.sv
module gsfb_scanout_tb;
  localparam int SW    = 16;
  localparam int SH    = 4;
  localparam int SC    = 4;
  localparam int RB    = SW / 2;
  localparam int OW    = SW * SC;
  localparam int OH    = SH * SC;
  localparam int FRAME = OW * OH;
  localparam int NADDR = SC * SH * RB;
  localparam int AW    = $clog2(SH * RB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [7:0] mem [0:SH*RB-1];

  logic          redraw_req = 1'b0;
  logic          pix_ready  = 1'b1;
  logic          redraw_pending;
  logic [AW-1:0] fb_addr;
  logic [7:0]    fb_rdata;
  logic          pix_valid, pix_sof, pix_eol;
  logic [15:0]   pix_data;

  logic          req24   = 1'b0;
  logic          ready24 = 1'b1;
  logic          pend24;
  logic [AW-1:0] addr24;
  logic [7:0]    rdata24;
  logic          valid24, sof24, eol24;
  logic [23:0]   data24;

  always @(posedge clk) begin
    fb_rdata <= mem[fb_addr];
    rdata24  <= mem[addr24];
  end

  gsfb_scanout #(.SRC_W(SW), .SRC_H(SH), .SCALE(SC), .COLOR24(1'b0)) u_dut (
    .clk(clk), .rst(rst), .redraw_req(redraw_req), .redraw_pending(redraw_pending),
    .fb_addr(fb_addr), .fb_rdata(fb_rdata), .pix_ready(pix_ready),
    .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_eol(pix_eol), .pix_data(pix_data));

  gsfb_scanout #(.SRC_W(SW), .SRC_H(SH), .SCALE(SC), .COLOR24(1'b1)) u_dut24 (
    .clk(clk), .rst(rst), .redraw_req(req24), .redraw_pending(pend24),
    .fb_addr(addr24), .fb_rdata(rdata24), .pix_ready(ready24),
    .pix_valid(valid24), .pix_sof(sof24), .pix_eol(eol24), .pix_data(data24));

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  logic [15:0] cap [0:2*OW-1];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] grey_at(input int p);
    int x, y, row, b;
    x   = p % OW;
    y   = p / OW;
    row = y / SC;
    b   = x / (2 * SC);
    return (((x / SC) % 2) == 0) ? mem[row*RB + b][7:4] : mem[row*RB + b][3:0];
  endfunction

  function automatic logic [15:0] exp16(input logic [3:0] g);
    logic [4:0] n;
    n = 5'(2 * int'(g) + int'(g >> 3));
    return {n, n, n[4], n};
  endfunction

  function automatic logic [23:0] exp24(input logic [3:0] g);
    return {g, g, g, g, g, g};
  endfunction

  function automatic int exp_addr(input int i);
    if (i >= NADDR) return 0;
    return (i / (SC * RB)) * RB + (i % RB);
  endfunction

  task automatic capture16(input int rmode, input int req_at, input int nframes,
                           output int npix, output int bdat, output int bsof,
                           output int beol, output int bstall, output int baddr,
                           output int naddr);
    bit pstall = 0, req_done = 0, r;
    logic [15:0] pd; logic ps, pe; logic [AW-1:0] pa, last_a;
    int p;
    npix = 0; bdat = 0; bsof = 0; beol = 0; bstall = 0; baddr = 0; naddr = 0;
    last_a = fb_addr; pd = '0; ps = 0; pe = 0; pa = '0;
    for (int cyc = 0; cyc < 20000 && npix < nframes * FRAME; cyc++) begin
      @(negedge clk);
      if (pstall && !(pix_valid && pix_data == pd && pix_sof == ps &&
                      pix_eol == pe && fb_addr == pa)) bstall++;
      if (fb_addr != last_a) begin
        if (int'(fb_addr) != exp_addr((naddr % NADDR) + 1)) baddr++;
        naddr++;
        last_a = fb_addr;
      end
      case (rmode)
        1:       r = (cyc % 3) != 0;
        2:       r = (cyc % 7) >= 3;
        default: r = 1'b1;
      endcase
      pix_ready = r;
      if (cyc == 0) redraw_req = 1'b1;
      else if (req_at >= 0 && npix >= req_at && !req_done) begin
        redraw_req = 1'b1;
        req_done = 1'b1;
      end else redraw_req = 1'b0;
      if (pix_valid && r) begin
        p = npix % FRAME;
        if (pix_data != exp16(grey_at(p))) bdat++;
        if (pix_sof != (p == 0)) bsof++;
        if (pix_eol != ((p % OW) == OW - 1)) beol++;
        if (npix < 2 * OW) cap[npix] = pix_data;
        npix++;
      end
      pstall = pix_valid && !r;
      pd = pix_data; ps = pix_sof; pe = pix_eol; pa = fb_addr;
    end
    redraw_req = 1'b0;
    pix_ready  = 1'b1;
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (i > 1 && pix_valid) seen++;
    end
    check(seen == 0, req, "pixels while nothing pending", seen, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!pix_valid && !pix_sof && !pix_eol, "R1", "stream flags after reset",
          {pix_valid, pix_sof, pix_eol}, 0);
    check(!redraw_pending, "R1", "pending after reset", redraw_pending, 0);
    check(fb_addr == '0, "R1", "address after reset", fb_addr, 0);
  endtask

  task automatic t_idle();
    expect_quiet("R2", 200);
    check(!redraw_pending, "R2", "pending without request", redraw_pending, 0);
  endtask

  task automatic t_single_frame();
    int n, bd, bs, be, bst, ba, na;
    logic [15:0] lineh;
    int rep_bad = 0;
    capture16(0, -1, 1, n, bd, bs, be, bst, ba, na);
    check(n == FRAME, "R3", "pixel count", n, FRAME);
    check(bs == 0, "R3", "sof placement errors", bs, 0);
    check(be == 0, "R3", "eol placement errors", be, 0);
    check(ba == 0, "R4", "address sequence errors", ba, 0);
    check(na == NADDR, "R4", "address changes per frame", na, NADDR);
    check(bd == 0, "R7", "pixel value errors", bd, 0);
    check(cap[0] == 16'hFFFF, "R5", "left pixel from high nibble", cap[0], 16'hFFFF);
    check(cap[SC] == 16'h0000, "R5", "right pixel from low nibble", cap[SC], 0);
    for (int i = 0; i < OW; i++) begin
      lineh = cap[(i / SC) * SC];
      if (cap[i] != lineh || cap[OW + i] != cap[i]) rep_bad++;
    end
    check(rep_bad == 0, "R6", "horizontal and vertical repeats", rep_bad, 0);
    check(cap[4*SC] == 16'h8C71, "R7", "grey 8 in RGB565", cap[4*SC], 16'h8C71);
    check(cap[5*SC] == 16'h1082, "R7", "grey 1 in RGB565", cap[5*SC], 16'h1082);
    repeat (3) @(negedge clk);
    check(!redraw_pending, "R9", "pending after frame end", redraw_pending, 0);
    expect_quiet("R2", 60);
  endtask

  task automatic t_backpressure(input int mode);
    int n, bd, bs, be, bst, ba, na;
    capture16(mode, -1, 1, n, bd, bs, be, bst, ba, na);
    check(bst == 0, "R11", "values changed during stall", bst, 0);
    check(n == FRAME && bd == 0 && bs == 0 && be == 0, "R11",
          "frame content under backpressure", bd + bs + be, 0);
    check(ba == 0, "R4", "address sequence under backpressure", ba, 0);
    repeat (3) @(negedge clk);
    check(!redraw_pending, "R9", "pending after stalled frame", redraw_pending, 0);
  endtask

  task automatic t_req_during_scan();
    int n, bd, bs, be, bst, ba, na;
    capture16(0, 300, 2, n, bd, bs, be, bst, ba, na);
    check(n == 2 * FRAME, "R10", "pixels for held request", n, 2 * FRAME);
    check(bs == 0 && bd == 0, "R10", "second frame content", bs + bd, 0);
    repeat (3) @(negedge clk);
    check(!redraw_pending, "R10", "pending after second frame", redraw_pending, 0);
    expect_quiet("R10", 60);
  endtask

  task automatic t_color24();
    int n = 0, bd = 0;
    logic [23:0] first = '0, g8 = '0;
    for (int cyc = 0; cyc < 5000 && n < FRAME; cyc++) begin
      @(negedge clk);
      req24 = (cyc == 0);
      if (valid24) begin
        if (data24 != exp24(grey_at(n))) bd++;
        if (n == 0) first = data24;
        if (n == 4 * SC) g8 = data24;
        n++;
      end
    end
    req24 = 1'b0;
    check(n == FRAME, "R8", "24-bit pixel count", n, FRAME);
    check(bd == 0, "R8", "24-bit value errors", bd, 0);
    check(first == 24'hFFFFFF, "R8", "grey 15 in RGB888", first, 24'hFFFFFF);
    check(g8 == 24'h888888, "R8", "grey 8 in RGB888", g8, 24'h888888);
  endtask

  initial begin
    for (int i = 0; i < SH * RB; i++) mem[i] = 8'((i * 37 + 5) & 255);
    mem[0] = 8'hF0;
    mem[2] = 8'h81;
    mem[RB] = 8'h3C;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle();
    t_single_frame();
    t_backpressure(1);
    t_backpressure(2);
    t_req_during_scan();
    t_color24();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule